// File: doc/BRIEF.md
# Write-to-acknowledge interrupt controller

This block collects one-cycle request pulses from up to sixteen peripheral sources and keeps each one in a latched status bit. Software sees two 16-bit registers on a simple synchronous bus. One is the pending status; the other is the enable mask. The block drives a single interrupt line to the processor. That line is high whenever a pending bit is also enabled.

Software acknowledges a source with a write to the status register. The written value is ANDed into the pending bits. A 0 in a bit position clears that bit, and a 1 leaves it as it was. This lets a handler clear exactly the sources it has serviced without a read-modify-write race.

The DMA engine's interrupt has its own pulse input, which lands on a fixed status bit. Requests and acknowledges can arrive in the same cycle; in that case the new request is kept.

Top module: `irq_ack_ctrl`

## Requirements
- R1: A write to offset 0x070 sets the status register to (old status AND written low 16 bits). A 1 keeps the bit and a 0 clears it.
- R2: A write to offset 0x074 replaces the mask register with the written low 16 bits.
- R3: A 1 on bit n of `src_pulse` sets status bit n at the next clock edge. The bit then stays set until a status write clears it.
- R4: If a source pulse and a status write that clears the same bit occur in the same cycle, the bit ends up set.
- R5: `irq_out` is high exactly when (status AND mask) is nonzero. It follows the registers in the cycle after any write or pulse.
- R6: Only bits 15:0 of `bus_wdata` are used. A 16-bit access (`bus_size` = 0) and a 32-bit access (`bus_size` = 1) behave the same.
- R7: `bus_rdata` returns the addressed register zero-extended to 32 bits. Any other offset reads 0, and a write to it changes neither register.
- R8: A pulse on `dma_pulse` sets status bit 3.
- R9: Reset (`rst_n` low) clears status and mask, so `irq_out` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_pulse | input | 16 | One-cycle request pulses, bit n sets status bit n |
| dma_pulse | input | 1 | One-cycle DMA-engine request, sets status bit 3 |
| bus_addr | input | 12 | Register offset inside the I/O window |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_size | input | 1 | Access size: 0 = 16-bit, 1 = 32-bit |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_out | output | 1 | Interrupt line to the processor |

## Verification
The embedded properties check the register behaviour on every cycle:
- the AND-acknowledge of the status register;
- a new request beating a simultaneous acknowledge;
- status holding when there is neither a write nor a pulse;
- mask loading and holding;
- the DMA input landing on bit 3;
- writes to other offsets leaving the mask alone;
- the interrupt line falling only after a register write.

Some behaviour can only be shown by the bench's scenarios. These are the exact values read back after a sequence of mixed pulses and acknowledges, the masking of upper write data for both access sizes, zero reads at unmapped offsets, and the clearing by a reset in mid-run.

// File: rtl/irq_ack_pkg.sv
package irq_ack_pkg;
   typedef enum logic {
      SZ_HALF = 1'b0,
      SZ_WORD = 1'b1
   } acc_size_e;

   localparam int unsigned REG_W_DEF  = 16;
   localparam int unsigned BUS_W_DEF  = 32;
   localparam int unsigned ADDR_W_DEF = 12;
endpackage

// File: rtl/irq_stat_bank.sv
module irq_stat_bank #(
   parameter int unsigned REG_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ack_we,
   input  logic [REG_W-1:0] ack_val,
   input  logic [REG_W-1:0] set_vec,
   output logic [REG_W-1:0] stat_q
);
   // one flop per pending bit; a request overrides a same-cycle acknowledge
   for (genvar b = 0; b < REG_W; b++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stat_q[b] <= 1'b0;
         else        stat_q[b] <= (stat_q[b] & (~ack_we | ack_val[b])) | set_vec[b];
      end
   end

   p_ack_and_r1: assert property (@(posedge clk) disable iff (!rst_n)
      ack_we |=> ((stat_q & ~$past(set_vec)) ==
                  ($past(stat_q) & $past(ack_val) & ~$past(set_vec))));

   p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (set_vec != '0) |=> ((stat_q & $past(set_vec)) == $past(set_vec)));

   p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!ack_we && set_vec == '0) |=> $stable(stat_q));
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
   parameter int unsigned REG_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ld,
   input  logic [REG_W-1:0] ld_val,
   output logic [REG_W-1:0] mask_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  mask_q <= '0;
      else if (ld) mask_q <= ld_val;
   end

   p_mask_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ld |=> (mask_q == $past(ld_val)));

   p_mask_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !ld |=> $stable(mask_q));
endmodule

// File: rtl/irq_read_mux.sv
module irq_read_mux
   import irq_ack_pkg::*;
#(
   parameter int unsigned   REG_W    = 16,
   parameter int unsigned   BUS_W    = 32,
   parameter int unsigned   ADDR_W   = 12,
   parameter logic [ADDR_W-1:0] STAT_OFS = 12'h070,
   parameter logic [ADDR_W-1:0] MASK_OFS = 12'h074
) (
   input  logic [ADDR_W-1:0] addr,
   input  acc_size_e         size,
   input  logic [REG_W-1:0]  stat_q,
   input  logic [REG_W-1:0]  mask_q,
   output logic [BUS_W-1:0]  rdata
);
   localparam int unsigned PAD_W = BUS_W - REG_W;

   logic [REG_W-1:0] sel;
   logic             size_unused;

   // both access sizes return the 16-bit value with zeroed upper bits
   assign size_unused = (size == SZ_WORD);

   always_comb begin
      if (addr == STAT_OFS)      sel = stat_q;
      else if (addr == MASK_OFS) sel = mask_q;
      else                       sel = '0;
      rdata = {{PAD_W{1'b0}}, sel};
   end
endmodule

// File: rtl/irq_ack_ctrl.sv
module irq_ack_ctrl
   import irq_ack_pkg::*;
#(
   parameter int unsigned REG_W    = REG_W_DEF,
   parameter int unsigned BUS_W    = BUS_W_DEF,
   parameter int unsigned ADDR_W   = ADDR_W_DEF,
   parameter logic [ADDR_W-1:0] STAT_OFS = 12'h070,
   parameter logic [ADDR_W-1:0] MASK_OFS = 12'h074,
   parameter int unsigned DMA_BIT  = 3,
   parameter bit          REG_IRQ  = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [REG_W-1:0]  src_pulse,
   input  logic              dma_pulse,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic              bus_size,
   input  logic [BUS_W-1:0]  bus_wdata,
   output logic [BUS_W-1:0]  bus_rdata,
   output logic              irq_out
);
   // elaboration-time parameter checks
   if (REG_W > BUS_W) begin : g_bad_width
      $error("irq_ack_ctrl: REG_W must not exceed BUS_W");
   end
   if (DMA_BIT >= REG_W) begin : g_bad_dma
      $error("irq_ack_ctrl: DMA_BIT out of range");
   end
   if (STAT_OFS == MASK_OFS) begin : g_bad_ofs
      $error("irq_ack_ctrl: register offsets collide");
   end

   localparam logic [REG_W-1:0] DMA_ONEHOT = REG_W'(1) << DMA_BIT;

   logic             wr_stat, wr_mask;
   logic [REG_W-1:0] wval, set_vec, stat_q, mask_q;
   logic             pend_any;
   logic [BUS_W-REG_W:0] hi_unused;

   assign wr_stat   = bus_we && (bus_addr == STAT_OFS);
   assign wr_mask   = bus_we && (bus_addr == MASK_OFS);
   assign wval      = bus_wdata[REG_W-1:0];
   assign hi_unused = {bus_wdata[BUS_W-1:REG_W], bus_size};
   assign set_vec   = src_pulse | (dma_pulse ? DMA_ONEHOT : '0);

   irq_stat_bank #(.REG_W(REG_W)) u_stat (
      .clk(clk), .rst_n(rst_n), .ack_we(wr_stat), .ack_val(wval),
      .set_vec(set_vec), .stat_q(stat_q));

   irq_mask_reg #(.REG_W(REG_W)) u_mask (
      .clk(clk), .rst_n(rst_n), .ld(wr_mask), .ld_val(wval), .mask_q(mask_q));

   irq_read_mux #(.REG_W(REG_W), .BUS_W(BUS_W), .ADDR_W(ADDR_W),
                  .STAT_OFS(STAT_OFS), .MASK_OFS(MASK_OFS)) u_rd (
      .addr(bus_addr), .size(acc_size_e'(bus_size)), .stat_q(stat_q),
      .mask_q(mask_q), .rdata(bus_rdata));

   assign pend_any = |(stat_q & mask_q);

   if (REG_IRQ) begin : g_irq_flop
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_out <= 1'b0;
         else        irq_out <= pend_any;
      end
   end else begin : g_irq_comb
      assign irq_out = pend_any;

      // the line can only drop because software wrote a register
      p_irq_fall_on_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(irq_out) |-> $past(wr_stat || wr_mask));
   end

   p_dma_sets_bit_r8: assert property (@(posedge clk) disable iff (!rst_n)
      dma_pulse |=> stat_q[DMA_BIT]);

   p_unmapped_no_effect_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && !wr_stat && !wr_mask) |=> $stable(mask_q));
endmodule

// File: tb/sim_irq_ack_ctrl.sv
module sim_irq_ack_ctrl;
   localparam int CLK_P = 10;
   localparam logic [11:0] A_STAT = 12'h070;
   localparam logic [11:0] A_MASK = 12'h074;
   localparam logic [11:0] A_NONE = 12'h078;

   typedef struct packed {
      logic        we;
      logic [11:0] addr;
      logic [31:0] data;
      logic        size;
      logic [15:0] pulse;
      logic [15:0] e_stat;
      logic [15:0] e_mask;
      logic        e_irq;
   } vec_t;

   localparam int NV = 8;
   localparam logic [$bits(vec_t)-1:0] VECS [NV] = '{
      {1'b0, A_STAT, 32'h0000_0000, 1'b0, 16'h00F0, 16'h00F0, 16'h0000, 1'b0}, // R3 latch
      {1'b1, A_MASK, 32'h0000_0010, 1'b1, 16'h0000, 16'h00F0, 16'h0010, 1'b1}, // R2 load
      {1'b1, A_STAT, 32'h0000_FFEF, 1'b0, 16'h0000, 16'h00E0, 16'h0010, 1'b0}, // R1 ack
      {1'b1, A_STAT, 32'h0000_FFFF, 1'b0, 16'h0010, 16'h00F0, 16'h0010, 1'b1}, // R4 keep
      {1'b1, A_STAT, 32'h0000_0000, 1'b1, 16'h0010, 16'h0010, 16'h0010, 1'b1}, // R4 wins
      {1'b1, A_MASK, 32'hABCD_0000, 1'b1, 16'h0000, 16'h0010, 16'h0000, 1'b0}, // R6 upper
      {1'b1, A_NONE, 32'h0000_0000, 1'b0, 16'h0000, 16'h0010, 16'h0000, 1'b0}, // R7 none
      {1'b1, A_STAT, 32'hFFFF_0000, 1'b0, 16'h0000, 16'h0000, 16'h0000, 1'b0}  // R6 half
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] src_pulse = '0;
   logic        dma_pulse = 1'b0;
   logic [11:0] bus_addr = '0;
   logic        bus_we = 1'b0;
   logic        bus_size = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq_out;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   irq_ack_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .src_pulse(src_pulse), .dma_pulse(dma_pulse),
      .bus_addr(bus_addr), .bus_we(bus_we), .bus_size(bus_size),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out));

   function automatic string vtag(int i);
      case (i)
         0: return "R3";
         1: return "R2";
         2: return "R1";
         3, 4: return "R4";
         6: return "R7";
         default: return "R6";
      endcase
   endfunction

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic rd(logic [11:0] a, logic sz, output logic [31:0] v);
      bus_addr = a; bus_size = sz; bus_we = 1'b0;
      #1 v = bus_rdata;
   endtask

   // drive at a falling edge, hold across one rising edge
   task automatic cyc(logic we, logic [11:0] a, logic [31:0] d, logic sz,
                      logic [15:0] p, logic dp);
      bus_we = we; bus_addr = a; bus_wdata = d; bus_size = sz;
      src_pulse = p; dma_pulse = dp;
      @(negedge clk);
      bus_we = 1'b0; src_pulse = '0; dma_pulse = 1'b0; bus_wdata = '0;
   endtask

   task automatic check_regs(string tag, logic [15:0] es, logic [15:0] em, logic ei);
      logic [31:0] v;
      rd(A_STAT, 1'b0, v); check({tag, " status"}, v, {16'h0, es});
      rd(A_MASK, 1'b0, v); check({tag, " mask"},   v, {16'h0, em});
      check("R5 irq", {31'h0, irq_out}, {31'h0, ei});
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_fail++; n_run++;
         $display("FAIL watchdog: actual hung expected done");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      @(negedge clk);
      check_regs("R9 reset", 16'h0, 16'h0, 1'b0);
      @(negedge clk); rst_n = 1'b1; @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         vec_t t;
         t = vec_t'(VECS[i]);
         cyc(t.we, t.addr, t.data, t.size, t.pulse, 1'b0);
         check_regs(vtag(i), t.e_stat, t.e_mask, t.e_irq);
      end

      // R8: DMA input lands on bit 3
      cyc(1'b1, A_MASK, 32'h0000_0008, 1'b0, 16'h0, 1'b0);
      check_regs("R5 masked idle", 16'h0000, 16'h0008, 1'b0);
      cyc(1'b0, A_STAT, 32'h0, 1'b0, 16'h0, 1'b1);
      check_regs("R8 dma", 16'h0008, 16'h0008, 1'b1);

      // R7: 32-bit read zero-extends, unmapped offset reads 0
      rd(A_STAT, 1'b1, v); check("R7 word read", v, 32'h0000_0008);
      rd(A_NONE, 1'b1, v); check("R7 unmapped read", v, 32'h0);

      // R3: a latched bit survives idle cycles
      repeat (3) @(negedge clk);
      check_regs("R3 hold", 16'h0008, 16'h0008, 1'b1);

      // R1: writing ones keeps everything
      cyc(1'b1, A_STAT, 32'h0000_FFFF, 1'b1, 16'h8001, 1'b0);
      check_regs("R1 keep ones", 16'h8009, 16'h0008, 1'b1);

      // R9: reset in mid-run
      rst_n = 1'b0; #1;
      check_regs("R9 midrun reset", 16'h0, 16'h0, 1'b0);
      @(negedge clk); rst_n = 1'b1; @(negedge clk);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule